// File: doc/BRIEF.md
# Translation walk request queue

This block sits between a TLB and a single page-table walk engine. The TLB hands it translation requests, each carrying a small identifier and a virtual address. The block makes sure that only one walk runs at a time. A request that arrives while nothing is queued or running is launched straight away. Any other request waits in a first-in, first-out queue.

When the engine reports that the running walk has finished, the block drops that entry and moves to the next one. The TLB can cancel a request that is still waiting, using a per-identifier cancel line. Before launching the next walk, the block therefore removes cancelled entries from the head of the queue. It removes at most a configurable number of them per completion, and reports each one back with a squash response carrying its identifier. If a cancelled entry is still at the head once that budget is spent, it is launched as an ordinary walk. Every launch is a one-cycle start pulse, with the identifier and virtual address held beside it.

Top module: `walk_queue`

## Requirements
- R1: When a request is accepted at a clock edge while no walk is active and the queue is empty, walk_start is high for one cycle, starting at the next clock edge. walk_id and walk_va carry the request's fields. The request's cancel bit is not consulted for this launch.
- R2: A request accepted while a walk is active is queued. Queued requests are launched in the order they were accepted.
- R3: At most one walk is active at a time. walk_start lasts exactly one cycle, and no further walk_start occurs until walk_done has been seen for the active walk.
- R4: walk_done ends the active walk and removes its entry. walk_done that arrives while no walk is active has no effect: the block stays idle, keeps req_ready high, and the next request launches as in R1.
- R5: After a completion, if cancel[id] is 1 for the head entry's identifier, that entry is removed and reported with one sq_valid pulse and sq_id = id. The block removes one such entry per cycle, in queue order, and does so before it launches the next walk. A head entry with cancel 0 is launched in the cycle after the completion is seen.
- R6: At most SQUASH_MAX entries are squashed per completion. A cancelled head entry still present after SQUASH_MAX squashes is launched as a normal walk.
- R7: When squashing empties the queue, the block goes idle, and the next request launches as in R1.
- R8: req_ready is low whenever DEPTH entries are held, the active walk included. A request is taken only at a clock edge where req_valid and req_ready are both high.
- R9: After reset, req_ready is high and both walk_start and sq_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Queue can accept a request |
| req_id | input | ID_W | Request identifier |
| req_va | input | VA_W | Virtual address to translate |
| cancel | input | 2**ID_W | Cancel flag, one per identifier |
| walk_start | output | 1 | One-cycle launch pulse to the walk engine |
| walk_id | output | ID_W | Identifier of the launched walk |
| walk_va | output | VA_W | Virtual address of the launched walk |
| walk_done | input | 1 | Walk engine finished the active walk |
| sq_valid | output | 1 | One-cycle squash response |
| sq_id | output | ID_W | Identifier of the squashed request |

## Verification
The bench builds the block with DEPTH=4, ID_W=3, VA_W=32 and SQUASH_MAX=2. With these values, one active walk plus three queued entries fills the queue. Three cancelled entries behind the active walk are then enough to use up the squash budget and force a cancelled head entry to launch. The short queue also lets the bench hold a request against a low req_ready and watch it enter only after a completion frees a slot.

// File: rtl/walk_queue.sv
module walk_queue #(
  parameter int DEPTH      = 4,
  parameter int ID_W       = 3,
  parameter int VA_W       = 32,
  parameter int SQUASH_MAX = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ID_W-1:0]       req_id,
  input  logic [VA_W-1:0]       req_va,
  input  logic [(1<<ID_W)-1:0]  cancel,
  output logic                  walk_start,
  output logic [ID_W-1:0]       walk_id,
  output logic [VA_W-1:0]       walk_va,
  input  logic                  walk_done,
  output logic                  sq_valid,
  output logic [ID_W-1:0]       sq_id
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int BUD_W = $clog2(SQUASH_MAX + 2);

  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_SCAN} st_t;

  st_t               state;
  logic [ID_W-1:0]   q_id [DEPTH];
  logic [VA_W-1:0]   q_va [DEPTH];
  logic [DEPTH-1:0]  q_started;
  logic [PTR_W-1:0]  head, tail;
  logic [CNT_W-1:0]  count;
  logic [BUD_W-1:0]  budget;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  logic empty, push, pop, head_cancel, finish, do_squash, do_launch;

  assign empty       = (count == '0);
  assign req_ready   = (count < CNT_W'(DEPTH));
  assign push        = req_valid && req_ready;
  assign head_cancel = cancel[q_id[head]];
  assign finish      = (state == ST_BUSY) && walk_done;
  assign do_squash   = (state == ST_SCAN) && !empty && head_cancel &&
                       (budget < BUD_W'(SQUASH_MAX));
  assign do_launch   = !empty && !q_started[head] &&
                       ((state == ST_IDLE) || ((state == ST_SCAN) && !do_squash));
  assign pop         = finish || do_squash;

  always_ff @(posedge clk) begin
    if (push) begin
      q_id[tail] <= req_id;
      q_va[tail] <= req_va;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      head       <= '0;
      tail       <= '0;
      count      <= '0;
      budget     <= '0;
      q_started  <= '0;
      walk_start <= 1'b0;
      walk_id    <= '0;
      walk_va    <= '0;
      sq_valid   <= 1'b0;
      sq_id      <= '0;
    end else begin
      walk_start <= do_launch;
      sq_valid   <= do_squash;
      if (do_launch) begin
        walk_id         <= q_id[head];
        walk_va         <= q_va[head];
        q_started[head] <= 1'b1;
      end
      if (do_squash) begin
        sq_id  <= q_id[head];
        budget <= budget + 1'b1;
      end
      if (push) begin
        q_started[tail] <= 1'b0;
        tail            <= step(tail);
      end
      if (pop) head <= step(head);
      count <= count + CNT_W'(push) - CNT_W'(pop);
      case (state)
        ST_IDLE: if (do_launch) state <= ST_BUSY;
        ST_BUSY: if (walk_done) begin
          state  <= ST_SCAN;
          budget <= '0;
        end
        ST_SCAN: begin
          if (do_launch)   state <= ST_BUSY;
          else if (empty)  state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic             chk_active;
  logic [BUD_W-1:0] chk_sq;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_active <= 1'b0;
      chk_sq     <= '0;
    end else begin
      chk_active <= (chk_active || walk_start) && !walk_done;
      if (walk_done)     chk_sq <= '0;
      else if (sq_valid) chk_sq <= chk_sq + 1'b1;
    end
  end

  // R3
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |-> !chk_active);
  // R3
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !walk_start);
  // R5
  sq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> !chk_active && !walk_start);
  // R6
  sq_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |-> chk_sq < BUD_W'(SQUASH_MAX));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R8
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && !walk_done && !sq_valid && state == ST_BUSY) |=> $stable(tail));
endmodule

// File: tb/walk_queue_test.sv
module walk_queue_test;
  localparam int DEPTH = 4, ID_W = 3, VA_W = 32, SQM = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [ID_W-1:0]      req_id = '0;
  logic [VA_W-1:0]      req_va = '0;
  logic [(1<<ID_W)-1:0] cancel = '0;
  logic                 walk_start, sq_valid;
  logic [ID_W-1:0]      walk_id, sq_id;
  logic [VA_W-1:0]      walk_va;
  logic                 eng_done = 1'b0, extra_done = 1'b0, walk_done;
  assign walk_done = eng_done | extra_done;

  walk_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .VA_W(VA_W), .SQUASH_MAX(SQM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_va(req_va), .cancel(cancel), .walk_start(walk_start),
    .walk_id(walk_id), .walk_va(walk_va), .walk_done(walk_done),
    .sq_valid(sq_valid), .sq_id(sq_id));

  int n_cmp = 0, n_bad = 0;
  int lat = 4;
  int ek[$];
  int eid[$];
  logic [VA_W-1:0] eva[$];
  string etag[$];

  task automatic expect_start(int id, logic [VA_W-1:0] va, string tag);
    ek.push_back(0); eid.push_back(id); eva.push_back(va); etag.push_back(tag);
  endtask

  task automatic expect_squash(int id, string tag);
    ek.push_back(1); eid.push_back(id); eva.push_back('0); etag.push_back(tag);
  endtask

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_evt(int k, int id, logic [VA_W-1:0] va);
    n_cmp++;
    if (ek.size() == 0) begin
      n_bad++;
      $display("FAIL R2 unexpected event actual kind=%0d id=%0d expected none", k, id);
    end else begin
      int xk = ek.pop_front();
      int xi = eid.pop_front();
      logic [VA_W-1:0] xv = eva.pop_front();
      string t = etag.pop_front();
      if (xk != k || xi != id || (k == 0 && xv != va)) begin
        n_bad++;
        $display("FAIL %s actual kind=%0d id=%0d va=%h expected kind=%0d id=%0d va=%h",
                 t, k, id, va, xk, xi, xv);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (walk_start) compare_evt(0, int'(walk_id), walk_va);
      if (sq_valid)   compare_evt(1, int'(sq_id), '0);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && walk_start) begin
        repeat (lat - 1) @(negedge clk);
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  task automatic send(int id, logic [VA_W-1:0] va);
    req_valid = 1'b1;
    req_id    = ID_W'(id);
    req_va    = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    while (ek.size() != 0) @(negedge clk);
    repeat (lat + 6) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R3 watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(req_ready == 1'b1, "R9 req_ready", int'(req_ready), 1);
    check(walk_start == 1'b0, "R9 walk_start", int'(walk_start), 0);
    check(sq_valid == 1'b0, "R9 sq_valid", int'(sq_valid), 0);

    // R1 immediate launch, one cycle after acceptance
    lat = 3;
    expect_start(1, 32'h1000_1000, "R1 launch");
    send(1, 32'h1000_1000);
    @(negedge clk);
    check(walk_start == 1'b1 && walk_id == 3'd1, "R1 launch timing", int'(walk_start), 1);
    settle();
    // R1 cancel bit not consulted on a direct launch
    cancel[2] = 1'b1;
    expect_start(2, 32'h2000_2000, "R1 cancelled direct launch");
    send(2, 32'h2000_2000);
    settle();
    cancel = '0;

    // R2 arrival order while a walk is active
    lat = 12;
    expect_start(3, 32'h0000_3000, "R2 order");
    expect_start(4, 32'h0000_4000, "R2 order");
    expect_start(5, 32'h0000_5000, "R2 order");
    expect_start(6, 32'h0000_6000, "R2 order");
    send(3, 32'h0000_3000);
    send(4, 32'h0000_4000);
    send(5, 32'h0000_5000);
    send(6, 32'h0000_6000);
    settle();

    // R5 squash of cancelled head entries
    lat = 10;
    cancel[2] = 1'b1; cancel[4] = 1'b1;
    expect_start(1, 32'hA000_0001, "R5 squash");
    expect_squash(2, "R5 squash");
    expect_squash(4, "R5 squash");
    expect_start(5, 32'hA000_0005, "R5 squash");
    send(1, 32'hA000_0001);
    send(2, 32'hA000_0002);
    send(4, 32'hA000_0004);
    send(5, 32'hA000_0005);
    settle();
    cancel = '0;

    // R5 and R7 squash after a later completion empties the queue
    cancel[3] = 1'b1;
    expect_start(1, 32'hB000_0001, "R5 later");
    expect_start(2, 32'hB000_0002, "R5 later");
    expect_squash(3, "R7 squash empties");
    send(1, 32'hB000_0001);
    send(2, 32'hB000_0002);
    send(3, 32'hB000_0003);
    settle();
    cancel = '0;
    lat = 3;
    expect_start(6, 32'hB000_0006, "R7 relaunch");
    send(6, 32'hB000_0006);
    @(negedge clk);
    check(walk_start == 1'b1 && walk_id == 3'd6, "R7 immediate after idle", int'(walk_start), 1);
    settle();

    // R6 squash budget exhausted, cancelled head launched
    lat = 10;
    cancel[1] = 1'b1; cancel[2] = 1'b1; cancel[3] = 1'b1;
    expect_start(0, 32'hC000_0000, "R6 budget");
    expect_squash(1, "R6 budget");
    expect_squash(2, "R6 budget");
    expect_start(3, 32'hC000_0003, "R6 cancelled head launched");
    send(0, 32'hC000_0000);
    send(1, 32'hC000_0001);
    send(2, 32'hC000_0002);
    send(3, 32'hC000_0003);
    settle();
    cancel = '0;

    // R8 full queue holds off a request
    lat = 30;
    expect_start(1, 32'hD000_0001, "R8 full");
    expect_start(2, 32'hD000_0002, "R8 full");
    expect_start(3, 32'hD000_0003, "R8 full");
    expect_start(4, 32'hD000_0004, "R8 full");
    expect_start(5, 32'hD000_0005, "R8 held request");
    send(1, 32'hD000_0001);
    send(2, 32'hD000_0002);
    send(3, 32'hD000_0003);
    send(4, 32'hD000_0004);
    check(req_ready == 1'b0, "R8 ready low when full", int'(req_ready), 0);
    req_valid = 1'b1; req_id = 3'd5; req_va = 32'hD000_0005;
    repeat (5) @(negedge clk);
    check(req_ready == 1'b0, "R8 ready stays low", int'(req_ready), 0);
    send(5, 32'hD000_0005);
    settle();

    // R4 completion while idle is ignored
    lat = 3;
    extra_done = 1'b1;
    @(negedge clk);
    extra_done = 1'b0;
    repeat (4) @(negedge clk);
    check(req_ready == 1'b1, "R4 ready after stray done", int'(req_ready), 1);
    check(walk_start == 1'b0 && sq_valid == 1'b0, "R4 no output after stray done",
          int'(walk_start), 0);
    expect_start(7, 32'hE000_0007, "R4 launch after stray done");
    send(7, 32'hE000_0007);
    @(negedge clk);
    check(walk_start == 1'b1 && walk_id == 3'd7, "R4 idle launch timing", int'(walk_start), 1);
    settle();

    check(ek.size() == 0, "R2 leftover expected events", ek.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule